// File: doc/BRIEF.md
# Voiceband Codec Control Unit

This block sits between the serial link engine and the converter paths of a voiceband codec. Each complete 16-bit word that arrives from the host comes with a tag. The tag says whether the word is a converter sample or a control word. Control words with a clear top bit rewrite the configuration register. Control words with a set top bit are read commands.

The configuration register drives the converter paths: the preamp enable, the input selector, the two high-pass bypass flags, the two power flags and the 3-bit output gain code. The gain code is also presented as a signed value in dB.

The block also decides what the transmitter sends and when. While both power flags are set, it loads one ADC sample per frame, after a fixed warm-up that follows the write which powered the codec up. When the host completes a request/ready pair, it loads the register contents instead, and the frame timing restarts from that point. It also holds the DAC sample: a new sample from the host is applied at the next frame, and the last one is repeated when none arrives.

The block sees whole words only; bit shifting is done elsewhere. The link engine tells the block when its own line is busy.

Top module: `codec_ctrl_core`

## Requirements
- R1: After reset the register is 0x0000. All configuration outputs are 0 and gain_db reads +6. tx_load is 0, and tx_word and dac_out are 0x0000.
- R2: A control word (in_is_data = 0) with bit 15 = 0 is a write. It stores bits 0–5 and 7–9. Bit 6 and bits 10–15 are always stored as 0. The fields are: bit 0 pre_on, bit 1 mux_aux, bit 2 dac_hpf_byp, bit 3 adc_hpf_byp, bit 4 ana_on, bit 5 dig_on, and bits 9:7 gain_code.
- R3: gain_db equals 6 − 3·gain_code, in two's complement. The codes 0 to 7 therefore give +6, +3, 0, −3, −6, −9, −12 and −15.
- R4: A control word with bit 15 = 1 never changes the register.
- R5: The control word 0xC000 (ready), received after 0x8000 (request), makes tx_load rise for one cycle on the cycle after the ready word is taken. That cycle has tx_is_reg = 1 and tx_word = {6'b0, register[9:0]}.
- R6: While link_busy is 1, a pending register reply is held back. It is loaded on the cycle after link_busy is seen low.
- R7: A ready word with no pending request is ignored, and so is any other control word with bit 15 set. Neither causes a load.
- R8: No sample load occurs unless ana_on and dig_on are both 1.
- R9: After the write that sets both power flags, the first sample load comes STARTUP_CLKS − WORD_LEN cycles after the cycle in which that word's in_done was high. WORD_LEN is 17, so this is 410 cycles after the word's start.
- R10: While powered, sample loads repeat every FRAME_CLKS cycles. Each carries the adc_sample value present on the cycle before the load, with tx_is_reg = 0.
- R11: After a register reply, the next sample load follows FRAME_CLKS cycles after the reply load.
- R12: dac_out changes only with a sample load. It then takes the most recent data word received (in_is_data = 1), and it keeps its value when no new word arrived.
- R13: When a write clears either power flag, sample loads stop, and tx_word keeps the last value that was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_done | input | 1 | One-cycle strobe: a received word is complete |
| in_is_data | input | 1 | Tag of the received word: 1 = sample, 0 = control |
| in_word | input | 16 | Received word |
| adc_sample | input | 16 | Current ADC output sample |
| link_busy | input | 1 | Transmitter is shifting a word |
| tx_load | output | 1 | One-cycle strobe: start sending tx_word |
| tx_is_reg | output | 1 | The loaded word is a register reply |
| tx_word | output | 16 | Word handed to the transmitter |
| dac_out | output | 16 | Sample applied to the DAC path |
| pre_on | output | 1 | Insert the +20 dB preamp |
| mux_aux | output | 1 | 1 = auxiliary input, 0 = normal input |
| dac_hpf_byp | output | 1 | Bypass the DAC high-pass filter |
| adc_hpf_byp | output | 1 | Bypass the ADC high-pass filter |
| ana_on | output | 1 | Analog section operating |
| dig_on | output | 1 | Digital section operating |
| gain_code | output | 3 | Output gain code |
| gain_db | output | 6 | Output gain in dB, two's complement |

## Verification
Each kind of internal fault shows at the ports in its own way and within a bounded time:
- A corrupted register shows at once on the field outputs. Where the field outputs hide it, it shows in the reply word that follows a request/ready pair on the next cycle.
- A read state machine stuck armed, or falsely armed, shows as a reply load after a stray ready word or an unknown command.
- A wrong warm-up or frame counter shows as a load shifted by a countable number of cycles against 392 or 325.
- A stale or early DAC buffer shows when dac_out is compared before and after a sample load.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int CW = 16;
  localparam logic [CW-1:0] RD_REQ_WORD = 16'h8000;
  localparam logic [CW-1:0] RD_RDY_WORD = 16'hC000;
  localparam logic [CW-1:0] CFG_KEEP    = 16'h03BF;

  // bit 9 down to bit 0 of the configuration register
  typedef struct packed {
    logic [2:0] gain;
    logic       spare;
    logic       dig_on;
    logic       ana_on;
    logic       adc_byp;
    logic       dac_byp;
    logic       mux_aux;
    logic       pre_on;
  } cfg_t;

  typedef enum logic [2:0] {
    WK_NONE, WK_WRITE, WK_RDREQ, WK_RDRDY, WK_DATA
  } word_kind_e;

  function automatic word_kind_e classify(input logic valid, input logic is_data,
                                          input logic [CW-1:0] w);
    if (!valid)                 return WK_NONE;
    else if (is_data)           return WK_DATA;
    else if (!w[CW-1])          return WK_WRITE;
    else if (w == RD_REQ_WORD)  return WK_RDREQ;
    else if (w == RD_RDY_WORD)  return WK_RDRDY;
    else                        return WK_NONE;
  endfunction

  function automatic cfg_t cfg_of(input logic [CW-1:0] w);
    logic [CW-1:0] m;
    m = w & CFG_KEEP;
    return cfg_t'(m[9:0]);
  endfunction

  function automatic logic [CW-1:0] word_of(input cfg_t c);
    return {6'd0, c};
  endfunction

  function automatic logic powered(input cfg_t c);
    return c.ana_on & c.dig_on;
  endfunction

  // 6 - 3*code, modulo 64 (two's complement)
  function automatic logic [5:0] gain_db_of(input logic [2:0] code);
    logic [5:0] one;
    logic [5:0] two;
    one = {3'b000, code};
    two = {2'b00, code, 1'b0};
    return 6'd6 - two - one;
  endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode import ccr_pkg::*; (
  input  logic          in_done,
  input  logic          in_is_data,
  input  logic [CW-1:0] in_word,
  output logic          wr_stb,
  output logic          rdreq_stb,
  output logic          rdrdy_stb,
  output logic          data_stb,
  output cfg_t          wr_cfg
);

  word_kind_e kind;

  always_comb begin
    kind      = classify(in_done, in_is_data, in_word);
    wr_stb    = (kind == WK_WRITE);
    rdreq_stb = (kind == WK_RDREQ);
    rdrdy_stb = (kind == WK_RDRDY);
    data_stb  = (kind == WK_DATA);
    wr_cfg    = cfg_of(in_word);
  end

endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile import ccr_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  cfg_t wr_cfg,
  input  logic rdreq_stb,
  input  logic rdrdy_stb,
  input  logic link_busy,
  input  logic slot_free,
  output cfg_t cfg,
  output logic reply_fire
);

  typedef enum logic [1:0] {RD_IDLE, RD_ARMED, RD_SEND} rd_st_e;
  rd_st_e rd_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (wr_stb) cfg <= wr_cfg;
  end

  assign reply_fire = (rd_st == RD_SEND) && !link_busy && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_st <= RD_IDLE;
    else begin
      case (rd_st)
        RD_IDLE:  if (rdreq_stb)  rd_st <= RD_ARMED;
        RD_ARMED: if (rdrdy_stb)  rd_st <= RD_SEND;
        RD_SEND:  if (reply_fire) rd_st <= RD_IDLE;
        default:                  rd_st <= RD_IDLE;
      endcase
    end
  end

  // R4: only a write strobe may move the register
  p_cfg_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cfg));

  // R5: a reply becomes due only right after a ready word
  p_send_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_st == RD_SEND) |-> $past(rdrdy_stb));

endmodule

// File: rtl/ccr_tx_sched.sv
module ccr_tx_sched import ccr_pkg::*; #(
  parameter int FRAME_CLKS   = 325,
  parameter int STARTUP_CLKS = 410,
  parameter int SYNC_LEAD    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_stb,
  input  logic          pwr_on,
  input  logic          reply_fire,
  input  logic [CW-1:0] reg_word,
  input  logic [CW-1:0] adc_sample,
  output logic          tx_load,
  output logic          tx_is_reg,
  output logic [CW-1:0] tx_word,
  output logic          data_fire
);

  localparam int WORD_LEN  = CW + SYNC_LEAD;
  localparam int WARM_LOAD = STARTUP_CLKS - WORD_LEN - 1;
  localparam int CNT_MAX   = (FRAME_CLKS > WARM_LOAD) ? FRAME_CLKS : WARM_LOAD;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {S_OFF, S_WARM, S_RUN} sch_st_e;
  sch_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic             cnt_last;

  assign cnt_last  = (cnt == CNT_W'(1));
  assign data_fire = (st != S_OFF) && cnt_last && pwr_on && !reply_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else if (start_stb) begin
      st  <= S_WARM;
      cnt <= CNT_W'(WARM_LOAD);
    end else if (!pwr_on) begin
      st  <= S_OFF;
      cnt <= '0;
    end else if (st != S_OFF) begin
      if ((reply_fire && (st == S_RUN || cnt_last)) || data_fire) begin
        st  <= S_RUN;
        cnt <= CNT_W'(FRAME_CLKS);
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_load   <= 1'b0;
      tx_is_reg <= 1'b0;
      tx_word   <= '0;
    end else begin
      tx_load <= data_fire || reply_fire;
      if (reply_fire) begin
        tx_is_reg <= 1'b1;
        tx_word   <= reg_word;
      end else if (data_fire) begin
        tx_is_reg <= 1'b0;
        tx_word   <= adc_sample;
      end
    end
  end

  // R8: a sample load needs both power flags in the cycle it was decided
  p_sample_needs_power_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !tx_is_reg) |-> $past(pwr_on));

  // R13: the outgoing word only moves together with a load
  p_word_moves_on_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_word) |-> tx_load);

endmodule

// File: rtl/ccr_dac_hold.sv
module ccr_dac_hold import ccr_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_stb,
  input  logic [CW-1:0] data_word,
  input  logic          frame_fire,
  output logic [CW-1:0] dac_out
);

  logic [CW-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      dac_out <= '0;
    end else begin
      if (data_stb)   pend    <= data_word;
      if (frame_fire) dac_out <= data_stb ? data_word : pend;
    end
  end

  // R12: the DAC sample moves only on a frame boundary
  p_dac_moves_on_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_out) |-> $past(frame_fire));

endmodule

// File: rtl/codec_ctrl_core.sv
module codec_ctrl_core import ccr_pkg::*; #(
  parameter int FRAME_CLKS   = 325,
  parameter int STARTUP_CLKS = 410,
  parameter int SYNC_LEAD    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_done,
  input  logic          in_is_data,
  input  logic [15:0]   in_word,
  input  logic [15:0]   adc_sample,
  input  logic          link_busy,
  output logic          tx_load,
  output logic          tx_is_reg,
  output logic [15:0]   tx_word,
  output logic [15:0]   dac_out,
  output logic          pre_on,
  output logic          mux_aux,
  output logic          dac_hpf_byp,
  output logic          adc_hpf_byp,
  output logic          ana_on,
  output logic          dig_on,
  output logic [2:0]    gain_code,
  output logic [5:0]    gain_db
);

  logic wr_stb, rdreq_stb, rdrdy_stb, data_stb;
  cfg_t wr_cfg, cfg;
  logic reply_fire, data_fire, start_stb;

  ccr_decode u_dec (
    .in_done(in_done), .in_is_data(in_is_data), .in_word(in_word),
    .wr_stb(wr_stb), .rdreq_stb(rdreq_stb), .rdrdy_stb(rdrdy_stb),
    .data_stb(data_stb), .wr_cfg(wr_cfg)
  );

  ccr_regfile u_reg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_cfg(wr_cfg),
    .rdreq_stb(rdreq_stb), .rdrdy_stb(rdrdy_stb), .link_busy(link_busy),
    .slot_free(!tx_load), .cfg(cfg), .reply_fire(reply_fire)
  );

  // warm-up starts only on the write that turns the codec on
  assign start_stb = wr_stb && powered(wr_cfg) && !powered(cfg);

  ccr_tx_sched #(
    .FRAME_CLKS(FRAME_CLKS), .STARTUP_CLKS(STARTUP_CLKS), .SYNC_LEAD(SYNC_LEAD)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .pwr_on(powered(cfg)),
    .reply_fire(reply_fire), .reg_word(word_of(cfg)), .adc_sample(adc_sample),
    .tx_load(tx_load), .tx_is_reg(tx_is_reg), .tx_word(tx_word),
    .data_fire(data_fire)
  );

  ccr_dac_hold u_dac (
    .clk(clk), .rst_n(rst_n), .data_stb(data_stb), .data_word(in_word),
    .frame_fire(data_fire), .dac_out(dac_out)
  );

  assign pre_on      = cfg.pre_on;
  assign mux_aux     = cfg.mux_aux;
  assign dac_hpf_byp = cfg.dac_byp;
  assign adc_hpf_byp = cfg.adc_byp;
  assign ana_on      = cfg.ana_on;
  assign dig_on      = cfg.dig_on;
  assign gain_code   = cfg.gain;
  assign gain_db     = gain_db_of(cfg.gain);

  // R6: a register reply never starts on a busy link
  p_reply_idle_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_is_reg) |-> $past(!link_busy));

  // R4: commands with the top bit set leave the configuration alone
  p_cmd_keeps_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_done && !in_is_data && in_word[15]) |=> $stable(gain_code) && $stable(ana_on) && $stable(dig_on));

endmodule

// File: tb/codec_ctrl_core_test.sv
module codec_ctrl_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 325;
  localparam int STARTUP    = 410;
  localparam int WORD_LEN   = 17;
  localparam int WD_LIMIT   = 20000;
  localparam int NV         = 12;

  // {word, pad, gain_db, gain_code, dig, ana, adc_byp, dac_byp, mux, pre}
  localparam logic [31:0] VEC [NV] = '{
    {16'h0001, 1'b0, 6'd6,      3'd0, 6'b000001},
    {16'h0002, 1'b0, 6'd6,      3'd0, 6'b000010},
    {16'h0004, 1'b0, 6'd6,      3'd0, 6'b000100},
    {16'h0008, 1'b0, 6'd6,      3'd0, 6'b001000},
    {16'h0080, 1'b0, 6'd3,      3'd1, 6'b000000},
    {16'h0100, 1'b0, 6'd0,      3'd2, 6'b000000},
    {16'h0180, 1'b0, 6'b111101, 3'd3, 6'b000000},
    {16'h0200, 1'b0, 6'b111010, 3'd4, 6'b000000},
    {16'h0280, 1'b0, 6'b110111, 3'd5, 6'b000000},
    {16'h0300, 1'b0, 6'b110100, 3'd6, 6'b000000},
    {16'h0380, 1'b0, 6'b110001, 3'd7, 6'b000000},
    {16'h7C43, 1'b0, 6'd6,      3'd0, 6'b000011}
  };

  logic clk, rst_n, in_done, in_is_data, link_busy;
  logic [15:0] in_word, adc_sample;
  logic tx_load, tx_is_reg;
  logic [15:0] tx_word, dac_out;
  logic pre_on, mux_aux, dac_hpf_byp, adc_hpf_byp, ana_on, dig_on;
  logic [2:0] gain_code;
  logic [5:0] gain_db;
  logic [14:0] obs;

  assign obs = {gain_db, gain_code, dig_on, ana_on, adc_hpf_byp, dac_hpf_byp, mux_aux, pre_on};

  codec_ctrl_core uut (
    .clk(clk), .rst_n(rst_n), .in_done(in_done), .in_is_data(in_is_data),
    .in_word(in_word), .adc_sample(adc_sample), .link_busy(link_busy),
    .tx_load(tx_load), .tx_is_reg(tx_is_reg), .tx_word(tx_word), .dac_out(dac_out),
    .pre_on(pre_on), .mux_aux(mux_aux), .dac_hpf_byp(dac_hpf_byp),
    .adc_hpf_byp(adc_hpf_byp), .ana_on(ana_on), .dig_on(dig_on),
    .gain_code(gain_code), .gain_db(gain_db)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic is_data, input logic [15:0] w);
    @(negedge clk);
    in_done = 1'b1; in_is_data = is_data; in_word = w;
    @(negedge clk);
    in_done = 1'b0; in_is_data = 1'b0; in_word = 16'h0000;
  endtask

  // negedges until tx_load is seen; k = limit+1 when none
  task automatic wait_load(input int limit, output int k);
    k = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (tx_load) begin k = i; break; end
    end
  endtask

  task automatic quiet(input int n, output int loads);
    loads = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_load) loads++;
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int k, loads;
    logic [15:0] held;
    rst_n = 1'b0; in_done = 1'b0; in_is_data = 1'b0; in_word = '0;
    adc_sample = '0; link_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 fields", {17'd0, obs}, {17'd0, 6'd6, 3'd0, 6'd0});
    check("R1 tx", {15'd0, tx_load, tx_word}, 32'd0);
    check("R1 dac", {16'd0, dac_out}, 32'd0);

    // R2 / R3 table walk
    for (int i = 0; i < NV; i++) begin
      send(1'b0, VEC[i][31:16]);
      check("R2 fields", {26'd0, obs[5:0]}, {26'd0, VEC[i][5:0]});
      check("R3 gain", {23'd0, obs[14:6]}, {23'd0, VEC[i][14:6]});
    end

    // R4: unknown command with top bit set keeps the register
    send(1'b0, 16'hA5A5);
    check("R4 cfg kept", {17'd0, obs}, {17'd0, 6'd6, 3'd0, 6'b000011});
    // R7: ready without request
    send(1'b0, 16'hC000);
    quiet(40, loads);
    check("R7 lone ready", loads, 0);

    // R5 read-back, reserved bits came back zero (R2)
    send(1'b0, 16'h8000);
    send(1'b0, 16'hC000);
    wait_load(10, k);
    check("R5 reply timing", k, 1);
    check("R5 reply kind", {31'd0, tx_is_reg}, 32'd1);
    check("R2 reply word", {16'd0, tx_word}, 32'h0003);

    // R6: reply held while link busy
    link_busy = 1'b1;
    send(1'b0, 16'h8000);
    send(1'b0, 16'hC000);
    quiet(20, loads);
    check("R6 held while busy", loads, 0);
    link_busy = 1'b0;
    wait_load(10, k);
    check("R6 reply after idle", k, 1);
    check("R6 reply kind", {31'd0, tx_is_reg}, 32'd1);

    // R7: unknown command does not arm the read
    send(1'b0, 16'h9000);
    send(1'b0, 16'hC000);
    quiet(40, loads);
    check("R7 unknown cmd", loads, 0);

    // R8: analog only, no samples; R13 tx_word keeps the reply
    send(1'b0, 16'h0013);
    quiet(STARTUP + FRAME, loads);
    check("R8 half power", loads, 0);
    check("R13 word kept", {16'd0, tx_word}, 32'h0003);

    // R9: power-up warm-up
    send(1'b1, 16'h2222);
    adc_sample = 16'h1111;
    send(1'b0, 16'h0130);
    wait_load(STARTUP + 20, k);
    check("R9 first load", k, STARTUP - WORD_LEN - 1);
    check("R10 sample word", {15'd0, tx_is_reg, tx_word}, {16'd0, 16'h1111});
    check("R12 dac first", {16'd0, dac_out}, 32'h2222);

    // R10 frame period, R12 hold with no new word
    adc_sample = 16'h3333;
    wait_load(FRAME + 20, k);
    check("R10 frame gap", k, FRAME);
    check("R10 sample word", {16'd0, tx_word}, 32'h3333);
    check("R12 dac repeated", {16'd0, dac_out}, 32'h2222);

    // R12 new word applied only at the frame
    send(1'b1, 16'h4444);
    check("R12 no early change", {16'd0, dac_out}, 32'h2222);
    wait_load(FRAME + 20, k);
    check("R12 dac updated", {16'd0, dac_out}, 32'h4444);

    // R11 reply during run restarts frame timing
    quiet(50, loads);
    send(1'b0, 16'h8000);
    send(1'b0, 16'hC000);
    wait_load(10, k);
    check("R5 reply in run", {15'd0, tx_is_reg, tx_word}, {15'd0, 1'b1, 16'h0130});
    wait_load(FRAME + 20, k);
    check("R11 gap after reply", k, FRAME);
    check("R11 data resumes", {31'd0, tx_is_reg}, 32'd0);

    // R13 power-down stops loads, word kept
    held = tx_word;
    send(1'b0, 16'h0020);
    quiet(2 * FRAME, loads);
    check("R13 no loads", loads, 0);
    check("R13 word held", {16'd0, tx_word}, {16'd0, held});

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule